// File: doc/BRIEF.md
# Gate Control List Cycle Executor

This block runs a time-gated schedule for a set of traffic gates. A list of up to `DEPTH` entries comes in on flat ports from a register file that the block does not own. Each entry holds one open/closed bit per gate and a 24-bit interval in nanoseconds. The block follows a time input given as seconds and nanoseconds, where the nanoseconds field wraps at 10^9. It drives one open flag per gate.

When gating is off, the gates stay open. They also stay open until the time input reaches a programmed base time, and while a configuration error is latched. From the base time onward, the block walks the list. It shows each entry's gate bits for that entry's interval. After the last valid entry it holds that entry's bits. At every cycle-time boundary, counted from the base time, it returns to entry 0.

The block tracks its position by subtracting the elapsed time between two samples from two countdowns. One countdown is for the current entry and one is for the current cycle. The overshoot past a boundary carries into the next entry or cycle, so boundaries do not drift over time.

Top module: `gcl_cycle_exec`

## Requirements
- R1: While `rst_n` is low, `gate_open` is all ones, and `cfg_err`, `active` and `cur_idx` are zero.
- R2: After any clock edge where `gate_en` was sampled low, or where the sampled time was earlier than the base time, `active` is 0, `cur_idx` is 0 and `gate_open` is all ones. The time comparison checks seconds first and nanoseconds only when the seconds are equal.
- R3: On the first sample where `gate_en` is high and time is at or after the base, `active` goes to 1 in the same clock edge. The offset between that time and the base time is already counted into entry 0 and into the cycle.
- R4: While active, `gate_open[g]` equals bit `g` of the current entry's gate field. Entry `i` occupies `list_gates[i*G_NUM +: G_NUM]`, where 1 means open and 0 means closed.
- R5: Let the offset within the current cycle be `p`. Entry `i` is current while `p` is at least the sum of intervals 0..i-1 and below the sum of intervals 0..i. Entry `i`'s interval is `list_ivl[i*24 +: 24]`.
- R6: If `p` reaches or passes the sum of all valid intervals, the last valid entry stays current until the cycle boundary.
- R7: When the offset from the base reaches a multiple of `cycle_ns`, the index returns to 0 and entry 0's interval starts again. This cuts short any entry that would run past the boundary.
- R8: Elapsed time is measured correctly across a rollover of the nanoseconds field from 999,999,999 to 0 with the seconds incremented.
- R9: If `gate_en` is high, `list_len` is 1, and entry 0's interval is less than or equal to `cycle_ns`, then `cfg_err` is 1 after the next edge. While `cfg_err` is 1, `active` is 0 and all gates are open.
- R10: `cfg_err` stays set, even if the configuration is repaired or `gate_en` drops. It clears only on an edge where `gate_en` rises. At that edge the configuration is checked again.
- R11: A `list_len` of 0 keeps the block inactive with all gates open. A `list_len` above `DEPTH` is treated as `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | Gating enable; a rising edge clears a latched error |
| now_sec | input | 32 | Current time, seconds |
| now_ns | input | 30 | Current time, nanoseconds (0 to 999,999,999) |
| base_sec | input | 32 | Schedule start time, seconds |
| base_ns | input | 30 | Schedule start time, nanoseconds |
| cycle_ns | input | 30 | Cycle period in nanoseconds |
| list_len | input | $clog2(DEPTH+1) | Number of valid entries |
| list_gates | input | DEPTH*G_NUM | Gate bits of all entries, entry i at i*G_NUM |
| list_ivl | input | DEPTH*IVL_W | Intervals of all entries, entry i at i*IVL_W |
| gate_open | output | G_NUM | Per-gate open flag (1 = open) |
| cfg_err | output | 1 | Latched single-entry configuration error |
| active | output | 1 | Schedule is running |
| cur_idx | output | $clog2(DEPTH) | Index of the current entry |

## Verification
If a countdown is off by even a nanosecond, it shows up as an index change one sample early or late. `gate_open` and `cur_idx` show that change on the first edge after the true boundary. Because the overshoot is carried forward, such an error then persists into every later boundary. A missed cycle restart shows as an index that keeps walking, or that stays on the last entry, where entry 0 was due within one sample. A wrong error latch shows up right away at the ports as gates forced open and `active` at 0. A bench model that works from absolute time modulo the cycle catches all of these on the cycle they occur.

// File: rtl/gcl_pkg.sv
package gcl_pkg;
  localparam int unsigned SEC_W = 32;
  localparam int unsigned NS_W  = 30;
  localparam logic [NS_W-1:0] NS_PER_SEC = 30'd1_000_000_000;

  typedef logic [NS_W-1:0] ns_t;

  function automatic ns_t sat_sub(ns_t a, ns_t b);
    return (a > b) ? ns_t'(a - b) : '0;
  endfunction
endpackage

// File: rtl/gcl_time_delta.sv
module gcl_time_delta
  import gcl_pkg::*;
(
  input  logic [SEC_W-1:0] now_sec,
  input  ns_t              now_ns,
  input  ns_t              prev_ns,
  input  logic [SEC_W-1:0] base_sec,
  input  ns_t              base_ns,
  output ns_t              step_ns,
  output logic             reached,
  output ns_t              start_off
);
  logic [SEC_W-1:0] sec_gap;

  assign sec_gap = now_sec - base_sec;

  always_comb begin
    // elapsed since previous sample, one nanosecond wrap allowed
    if (now_ns >= prev_ns) step_ns = now_ns - prev_ns;
    else                   step_ns = now_ns + (NS_PER_SEC - prev_ns);

    // seconds decide first, nanoseconds only on a tie
    if (now_sec != base_sec) reached = (now_sec > base_sec);
    else                     reached = (now_ns >= base_ns);

    // distance past base on the starting sample; beyond one second it is dropped
    if (sec_gap == '0)                     start_off = now_ns - base_ns;
    else if (sec_gap == SEC_W'(1))         start_off = now_ns + (NS_PER_SEC - base_ns);
    else                                   start_off = '0;
  end
endmodule

// File: rtl/gcl_advance.sv
module gcl_advance
  import gcl_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic [IDX_W-1:0] cur_idx,
  input  ns_t              cur_ivl,
  input  ns_t              cur_cyc,
  input  ns_t              elapsed,
  input  logic             is_last,
  input  ns_t              nxt_ivl,
  input  ns_t              first_ivl,
  input  ns_t              cycle_ns,
  output logic [IDX_W-1:0] new_idx,
  output ns_t              new_ivl,
  output ns_t              new_cyc
);
  ns_t over_cyc;
  ns_t over_ivl;

  assign over_cyc = elapsed - cur_cyc;
  assign over_ivl = elapsed - cur_ivl;

  always_comb begin
    new_idx = cur_idx;
    new_ivl = cur_ivl - elapsed;
    new_cyc = cur_cyc - elapsed;
    if (elapsed >= cur_cyc) begin
      // cycle boundary wins over any entry boundary
      new_idx = '0;
      new_cyc = sat_sub(cycle_ns, over_cyc);
      new_ivl = sat_sub(first_ivl, over_cyc);
    end else if (elapsed >= cur_ivl) begin
      if (!is_last) begin
        new_idx = cur_idx + 1'b1;
        new_ivl = sat_sub(nxt_ivl, over_ivl);
      end else begin
        new_ivl = '0;
      end
    end
  end
endmodule

// File: rtl/gcl_cfg_check.sv
module gcl_cfg_check
  import gcl_pkg::*;
#(
  parameter int unsigned LEN_W = 4
) (
  input  logic             gate_en,
  input  logic             en_q,
  input  logic             err_q,
  input  logic [LEN_W-1:0] list_len,
  input  ns_t              first_ivl,
  input  ns_t              cycle_ns,
  output logic             err_n
);
  logic single_bad;
  logic en_rise;

  assign single_bad = (list_len == LEN_W'(1)) && (first_ivl <= cycle_ns);
  assign en_rise    = gate_en & ~en_q;
  assign err_n      = (err_q & ~en_rise) | (gate_en & single_bad);
endmodule

// File: rtl/gcl_cycle_exec.sv
module gcl_cycle_exec
  import gcl_pkg::*;
#(
  parameter int unsigned G_NUM = 4,   // gates per entry
  parameter int unsigned DEPTH = 8,   // list entries, at least 2
  parameter int unsigned IVL_W = 24,  // interval field width
  localparam int unsigned LEN_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   gate_en,
  input  logic [31:0]            now_sec,
  input  logic [29:0]            now_ns,
  input  logic [31:0]            base_sec,
  input  logic [29:0]            base_ns,
  input  logic [29:0]            cycle_ns,
  input  logic [LEN_W-1:0]       list_len,
  input  logic [DEPTH*G_NUM-1:0] list_gates,
  input  logic [DEPTH*IVL_W-1:0] list_ivl,
  output logic [G_NUM-1:0]       gate_open,
  output logic                   cfg_err,
  output logic                   active,
  output logic [IDX_W-1:0]       cur_idx
);
  ns_t              ivl_arr [DEPTH];
  logic [G_NUM-1:0] gts_arr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_unpack
    assign ivl_arr[i] = ns_t'(list_ivl[i*IVL_W +: IVL_W]);
    assign gts_arr[i] = list_gates[i*G_NUM +: G_NUM];
  end

  // registers
  logic             en_q, err_q, run_q;
  logic [IDX_W-1:0] idx_q;
  ns_t              ivl_q, cyc_q, prev_ns_q;
  logic [G_NUM-1:0] gate_q;

  // next-state
  logic             err_n, run_n;
  logic [IDX_W-1:0] idx_n;
  ns_t              ivl_n, cyc_n;
  logic [G_NUM-1:0] gate_n;
  logic             st_ce;

  logic [LEN_W-1:0] eff_len;
  logic             last_run, last_start, can_run, reached;
  logic [IDX_W-1:0] nxt_idx;
  ns_t              step_ns, start_off;
  logic [IDX_W-1:0] rn_idx, st_idx;
  ns_t              rn_ivl, rn_cyc, st_ivl, st_cyc;

  assign eff_len    = (list_len > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : list_len;
  assign last_run   = (LEN_W'(idx_q) + LEN_W'(1)) >= eff_len;
  assign last_start = eff_len <= LEN_W'(1);
  assign nxt_idx    = last_run ? idx_q : idx_q + 1'b1;

  gcl_time_delta u_time (
    .now_sec  (now_sec),
    .now_ns   (now_ns),
    .prev_ns  (prev_ns_q),
    .base_sec (base_sec),
    .base_ns  (base_ns),
    .step_ns  (step_ns),
    .reached  (reached),
    .start_off(start_off)
  );

  gcl_cfg_check #(.LEN_W(LEN_W)) u_cfg (
    .gate_en  (gate_en),
    .en_q     (en_q),
    .err_q    (err_q),
    .list_len (list_len),
    .first_ivl(ivl_arr[0]),
    .cycle_ns (cycle_ns),
    .err_n    (err_n)
  );

  // position while already running
  gcl_advance #(.IDX_W(IDX_W)) u_run (
    .cur_idx  (idx_q),
    .cur_ivl  (ivl_q),
    .cur_cyc  (cyc_q),
    .elapsed  (step_ns),
    .is_last  (last_run),
    .nxt_ivl  (ivl_arr[nxt_idx]),
    .first_ivl(ivl_arr[0]),
    .cycle_ns (cycle_ns),
    .new_idx  (rn_idx),
    .new_ivl  (rn_ivl),
    .new_cyc  (rn_cyc)
  );

  // position on the starting sample: entry 0 with the start offset consumed
  gcl_advance #(.IDX_W(IDX_W)) u_start (
    .cur_idx  ('0),
    .cur_ivl  (ivl_arr[0]),
    .cur_cyc  (cycle_ns),
    .elapsed  (start_off),
    .is_last  (last_start),
    .nxt_ivl  (ivl_arr[1]),
    .first_ivl(ivl_arr[0]),
    .cycle_ns (cycle_ns),
    .new_idx  (st_idx),
    .new_ivl  (st_ivl),
    .new_cyc  (st_cyc)
  );

  assign can_run = gate_en & ~err_n & (eff_len != '0) & reached;
  assign st_ce   = can_run | run_q;

  always_comb begin
    run_n = run_q;
    idx_n = idx_q;
    ivl_n = ivl_q;
    cyc_n = cyc_q;
    if (!can_run) begin
      run_n = 1'b0;
      idx_n = '0;
      ivl_n = '0;
      cyc_n = '0;
    end else if (!run_q) begin
      run_n = 1'b1;
      idx_n = st_idx;
      ivl_n = st_ivl;
      cyc_n = st_cyc;
    end else begin
      idx_n = rn_idx;
      ivl_n = rn_ivl;
      cyc_n = rn_cyc;
    end
    gate_n = run_n ? gts_arr[idx_n] : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      err_q     <= 1'b0;
      prev_ns_q <= '0;
    end else begin
      en_q      <= gate_en;
      err_q     <= err_n;
      prev_ns_q <= now_ns;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      idx_q  <= '0;
      ivl_q  <= '0;
      cyc_q  <= '0;
      gate_q <= '1;
    end else if (st_ce) begin
      run_q  <= run_n;
      idx_q  <= idx_n;
      ivl_q  <= ivl_n;
      cyc_q  <= cyc_n;
      gate_q <= gate_n;
    end
  end

  assign gate_open = gate_q;
  assign cfg_err   = err_q;
  assign active    = run_q;
  assign cur_idx   = idx_q;
endmodule

// File: rtl/gcl_cycle_exec_chk.sv
module gcl_cycle_exec_chk #(
  parameter int unsigned G_NUM = 4,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IVL_W = 24,
  localparam int unsigned LEN_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   gate_en,
  input logic [29:0]            cycle_ns,
  input logic [LEN_W-1:0]       list_len,
  input logic [DEPTH*IVL_W-1:0] list_ivl,
  input logic [G_NUM-1:0]       gate_open,
  input logic                   cfg_err,
  input logic                   active,
  input logic [IDX_W-1:0]       cur_idx
);
  logic [29:0] ivl0;
  assign ivl0 = 30'(list_ivl[IVL_W-1:0]);

  AST_IDLE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> gate_open == '1); // R2

  AST_NO_EN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gate_en) |-> !active); // R2

  AST_IDX_IN_LIST: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> LEN_W'(cur_idx) < list_len); // R5

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |->
      (cur_idx == $past(cur_idx) || 32'(cur_idx) == 32'($past(cur_idx)) + 1 || cur_idx == '0)); // R7

  AST_SINGLE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && list_len == LEN_W'(1) && ivl0 <= cycle_ns) |=> cfg_err); // R9

  AST_ERR_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!active && gate_open == '1)); // R9

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_err) |-> ($past(gate_en) && !$past(gate_en, 2))); // R10
endmodule

bind gcl_cycle_exec gcl_cycle_exec_chk #(.G_NUM(G_NUM), .DEPTH(DEPTH), .IVL_W(IVL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gate_en  (gate_en),
  .cycle_ns (cycle_ns),
  .list_len (list_len),
  .list_ivl (list_ivl),
  .gate_open(gate_open),
  .cfg_err  (cfg_err),
  .active   (active),
  .cur_idx  (cur_idx)
);

// File: tb/gcl_cycle_exec_test.sv
module gcl_cycle_exec_test;
  localparam int G_NUM = 4;
  localparam int DEPTH = 8;
  localparam int IVL_W = 24;
  localparam int LEN_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);
  localparam longint NS = 64'd1_000_000_000;

  logic                   clk, rst_n, gate_en;
  logic [31:0]            now_sec, base_sec;
  logic [29:0]            now_ns, base_ns, cycle_ns;
  logic [LEN_W-1:0]       list_len;
  logic [DEPTH*G_NUM-1:0] list_gates;
  logic [DEPTH*IVL_W-1:0] list_ivl;
  logic [G_NUM-1:0]       gate_open;
  logic                   cfg_err, active;
  logic [IDX_W-1:0]       cur_idx;

  logic [G_NUM-1:0] gts_b [DEPTH];
  logic [IVL_W-1:0] ivl_b [DEPTH];

  longint t_tot, b_tot, t_s;
  bit     en_s, done;
  int     n_chk, n_fail;
  int     seed_dummy;

  gcl_cycle_exec #(.G_NUM(G_NUM), .DEPTH(DEPTH), .IVL_W(IVL_W)) uut (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en),
    .now_sec(now_sec), .now_ns(now_ns), .base_sec(base_sec), .base_ns(base_ns),
    .cycle_ns(cycle_ns), .list_len(list_len), .list_gates(list_gates), .list_ivl(list_ivl),
    .gate_open(gate_open), .cfg_err(cfg_err), .active(active), .cur_idx(cur_idx)
  );

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      list_gates[i*G_NUM +: G_NUM] = gts_b[i];
      list_ivl[i*IVL_W +: IVL_W]   = ivl_b[i];
    end
  end

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive_time();
    now_sec = 32'(t_tot / NS);
    now_ns  = 30'(t_tot % NS);
  endtask

  task automatic set_base(input longint b);
    b_tot    = b;
    base_sec = 32'(b / NS);
    base_ns  = 30'(b % NS);
  endtask

  // expected state from absolute time: offset modulo cycle, then walk the intervals
  function automatic void model(input longint t, output bit on, output int idx,
                                output string tag);
    longint off, pos, acc;
    int len;
    len = (int'(list_len) > DEPTH) ? DEPTH : int'(list_len);
    off = t - b_tot;
    on  = en_s && (len > 0) && (off >= 0);
    idx = 0;
    if (!on) begin
      tag = (len == 0) ? "R11" : "R2";
      return;
    end
    pos = off % longint'(cycle_ns);
    acc = 0;
    idx = len - 1;
    tag = "R6";
    for (int i = 0; i < len; i++) begin
      acc += longint'(ivl_b[i]);
      if (pos < acc) begin
        idx = i;
        tag = (i == 0 && off < longint'(cycle_ns)) ? "R3" : "R5";
        break;
      end
    end
    if (off >= longint'(cycle_ns) && idx == 0) tag = "R7";
    if (int'(list_len) > DEPTH) tag = "R11";
  endfunction

  // one clock: snapshot the driven inputs, check after the edge, advance time
  task automatic tick(input int st);
    bit on;
    int idx;
    string tg;
    logic [G_NUM-1:0] eg;
    en_s = gate_en;
    t_s  = t_tot;
    @(negedge clk);
    model(t_s, on, idx, tg);
    eg = on ? gts_b[idx] : '1;
    check(active == on, tg, "active", active, on);
    check(int'(cur_idx) == idx, tg, "index", cur_idx, idx);
    check(gate_open == eg, (on && (t_s / NS) != (b_tot / NS)) ? "R8" : "R4",
          "gates", gate_open, eg);
    check(cfg_err == 1'b0, "R9", "no error", cfg_err, 0);
    t_tot += st;
    drive_time();
  endtask

  task automatic run(input longint base, input longint lead, input int len,
                     input int cyc, input int lo, input int hi, input int smax,
                     input int n);
    gate_en = 1'b0;
    tick(5);
    tick(5);
    set_base(base);
    cycle_ns = 30'(cyc);
    list_len = LEN_W'(len);
    for (int i = 0; i < DEPTH; i++) begin
      ivl_b[i] = IVL_W'(lo + int'($urandom % (hi - lo + 1)));
      gts_b[i] = G_NUM'($urandom);
    end
    t_tot = base - lead;
    drive_time();
    gate_en = 1'b1;
    repeat (n) tick(1 + int'($urandom % smax));
    gate_en = 1'b0;
    tick(1);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    seed_dummy = $urandom(32'h5eed_61c1);
    rst_n = 1'b0; gate_en = 1'b0;
    t_tot = 0; drive_time(); set_base(0);
    cycle_ns = 30'd1000; list_len = '0;
    for (int i = 0; i < DEPTH; i++) begin ivl_b[i] = '0; gts_b[i] = '0; end
    #10;
    check(gate_open == '1, "R1", "reset gates", gate_open, 15);
    check(cfg_err == 1'b0, "R1", "reset err", cfg_err, 0);
    check(active == 1'b0, "R1", "reset active", active, 0);
    check(cur_idx == '0, "R1", "reset index", cur_idx, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // seconds field earlier while nanoseconds field larger: must stay closed-off (R2), hold last (R6)
    run(7 * NS + 100, 1100, 4, 2000, 100, 300, 30, 1500);
    // cycle shorter than list: cut short (R7), crossing a second while running (R8)
    run(12 * NS + 999_999_000, 3000, 8, 1000, 100, 250, 40, 2500);
    // valid single entry longer than cycle
    run(20 * NS + 500, 700, 1, 300, 400, 600, 50, 600);
    // empty list (R11)
    run(25 * NS, 400, 0, 800, 100, 200, 30, 200);
    // length above depth clamps (R11)
    run(30 * NS + 77, 900, 12, 5000, 100, 200, 40, 1500);
    for (int r = 0; r < 3; r++) begin
      run((40 + r) * NS + longint'($urandom % 1_000_000), 500, 2 + int'($urandom % 7),
          500 + int'($urandom % 2500), 60, 400, 50, 800);
    end

    // directed error sequence
    gate_en = 1'b0;
    @(negedge clk);
    list_len = LEN_W'(1);
    ivl_b[0] = 200;
    cycle_ns = 30'd200;
    set_base(t_tot);
    gate_en = 1'b1;
    @(negedge clk);
    check(cfg_err == 1'b1, "R9", "equal interval error", cfg_err, 1);
    check(gate_open == '1, "R9", "error gates open", gate_open, 15);
    check(active == 1'b0, "R9", "error inactive", active, 0);
    ivl_b[0] = 500;
    repeat (3) @(negedge clk);
    check(cfg_err == 1'b1, "R10", "sticky after repair", cfg_err, 1);
    gate_en = 1'b0;
    repeat (2) @(negedge clk);
    check(cfg_err == 1'b1, "R10", "sticky with enable low", cfg_err, 1);
    t_tot += 10; drive_time(); set_base(t_tot);
    gate_en = 1'b1;
    @(negedge clk);
    check(cfg_err == 1'b0, "R10", "cleared on enable rise", cfg_err, 0);
    check(active == 1'b1, "R10", "runs after clear", active, 1);
    check(gate_open == gts_b[0], "R10", "entry 0 gates", gate_open, gts_b[0]);
    ivl_b[0] = 100;
    @(negedge clk);
    check(cfg_err == 1'b1, "R9", "shorter interval error", cfg_err, 1);
    check(active == 1'b0, "R9", "error stops run", active, 0);
    gate_en = 1'b0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule